// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address of each access in a four-beat burst behind a synchronous memory port. When a cycle start is accepted, it captures the external address as the burst's start point. On each qualified advance, it produces the next burst position by changing only the two low address bits. The upper bits stay fixed for the whole burst.

A static order input selects how the low bits move. In the interleaved order, the start's low bits are XORed with the beat number. In the linear order, the beat number is added to them modulo four. After the fourth beat, a further advance returns to the start address. A write burst advances only on edges that also carry a byte write.

Top module: `burst_seq`

## Requirements
- R1: With `order_sel` = 1, the low two bits of `cur_addr` on beats 0..3 equal start[1:0] XOR 0, 1, 2, 3.
- R2: With `order_sel` = 0, the low two bits on beats 0..3 equal (start[1:0] + 0, 1, 2, 3) mod 4. Bits above bit 1 never change except on a load.
- R3: A load happens on an edge where `start_ok` = 1 and at least one of `strb_p_n`, `strb_c_n` is 0. The next cycle, `cur_addr` equals the `ext_addr` sampled on that edge, at beat 0.
- R4: On a load edge, `adv_n` has no effect: the output is the new start address even when `adv_n` = 0.
- R5: Outside a load, the burst steps only when `adv_n` = 0 and both strobes are 1. A strobe at 0 with `start_ok` = 0 holds the address.
- R6: With `adv_n` = 1 and no load, the address is held (wait state).
- R7: Write mode starts in two cases:
  - a load by `strb_c_n` = 0 with `strb_p_n` = 1 samples `wbeat_n` = 0;
  - `wbeat_n` = 0 is sampled on a non-load edge.

  Any other load clears write mode. In write mode, an advance steps only when `wbeat_n` = 0.
- R8: An advance after beat 3 returns `cur_addr` to the start address (beat 0).
- R9: With `rst_n` = 0 at a clock edge, the start address and beat count both become zero, so `cur_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_ok | input | 1 | A strobe on this edge may start a cycle |
| strb_p_n | input | 1 | Processor address strobe, active low |
| strb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wbeat_n | input | 1 | Byte write on this edge, active low |
| order_sel | input | 1 | 1 = XOR order, 0 = linear order |
| ext_addr | input | AW | External start address |
| cur_addr | output | AW | Address of the current access |

## Verification
The main collision is a load and an advance on the same edge. The bench drives `adv_n` low together with a strobe that starts a new burst, in the middle of a running burst. It expects the fresh start address and not the next beat. A second collision puts a byte write and an advance on the edge that enters write mode. That edge must still step, while a later write-mode edge without a byte write must hold. Every cycle is compared against a behavioural model built from integers.

// File: rtl/burst_seq_pkg.sv
// Package: shared helpers for the burst sequencer.
package burst_seq_pkg;
    // Low two address bits of beat n for a burst starting at lsb.
    function automatic logic [1:0] beat_lsb(input logic [1:0] lsb,
                                            input logic [1:0] n,
                                            input logic       xor_order);
        beat_lsb = xor_order ? (lsb ^ n) : (lsb + n);
    endfunction
endpackage

// File: rtl/burst_seq_ctrl.sv
// Control decode: turns strobes, advance and byte-write into load and
// step pulses and tracks write mode.
// Assumes all inputs are synchronous to clk.
module burst_seq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic strb_p_n,
    input  logic strb_c_n,
    input  logic adv_n,
    input  logic wbeat_n,
    output logic load_en,
    output logic step_en,
    output logic wr_mode
);
    logic strobes_idle;

    // Load and step decode; a load outranks any advance.
    always_comb begin
        strobes_idle = strb_p_n & strb_c_n;
        load_en      = start_ok & ~strobes_idle;
        step_en      = ~load_en & strobes_idle & ~adv_n
                       & (~(wr_mode | ~wbeat_n) | ~wbeat_n);
    end

    // Write-mode flag: set by a byte write, cleared by other loads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_mode <= 1'b0;
        else if (load_en)
            wr_mode <= strb_p_n & ~wbeat_n;
        else if (!wbeat_n)
            wr_mode <= 1'b1;
    end
endmodule

// File: rtl/burst_seq_state.sv
// Burst state: holds the captured start address and the beat counter.
// Assumes load_en and step_en are never high together.
module burst_seq_state #(
    parameter int AW = 16,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          step_en,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] base_addr,
    output logic [BW-1:0] beat
);
    // Capture the start on load, count beats on step, wrap modulo 2**BW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            beat      <= '0;
        end else if (load_en) begin
            base_addr <= ext_addr;
            beat      <= '0;
        end else if (step_en) begin
            beat      <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/burst_seq_map.sv
// Address mapper: combines the start address and the beat into the
// access address. Only the low BW bits are altered.
module burst_seq_map #(
    parameter int AW = 16,
    parameter int BW = 2
) (
    input  logic          order_sel,
    input  logic [AW-1:0] base_addr,
    input  logic [BW-1:0] beat,
    output logic [AW-1:0] cur_addr
);
    import burst_seq_pkg::*;

    // Upper bits pass straight through.
    genvar gi;
    generate
        for (gi = BW; gi < AW; gi++) begin : g_upper
            assign cur_addr[gi] = base_addr[gi];
        end
    endgenerate

    // Low bits follow the selected burst order.
    always_comb begin
        cur_addr[BW-1:0] = beat_lsb(base_addr[BW-1:0], beat, order_sel);
    end
endmodule

// File: rtl/burst_seq.sv
// Top of the four-beat burst address sequencer.
// Assumes order_sel is static while a burst runs.
module burst_seq #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_ok,
    input  logic          strb_p_n,
    input  logic          strb_c_n,
    input  logic          adv_n,
    input  logic          wbeat_n,
    input  logic          order_sel,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] cur_addr
);
    localparam int BW = 2;

    logic          load_en;
    logic          step_en;
    logic          wr_mode;
    logic [AW-1:0] base_addr;
    logic [BW-1:0] beat;

    burst_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
        .strb_p_n(strb_p_n), .strb_c_n(strb_c_n), .adv_n(adv_n),
        .wbeat_n(wbeat_n), .load_en(load_en), .step_en(step_en),
        .wr_mode(wr_mode)
    );

    burst_seq_state #(.AW(AW), .BW(BW)) u_state (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en),
        .ext_addr(ext_addr), .base_addr(base_addr), .beat(beat)
    );

    burst_seq_map #(.AW(AW), .BW(BW)) u_map (
        .order_sel(order_sel), .base_addr(base_addr), .beat(beat),
        .cur_addr(cur_addr)
    );
endmodule

// File: rtl/burst_seq_chk.sv
// Checker for burst_seq: temporal properties on ports and control pulses.
module burst_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strb_p_n,
    input logic          strb_c_n,
    input logic          adv_n,
    input logic          wbeat_n,
    input logic [AW-1:0] ext_addr,
    input logic [AW-1:0] cur_addr,
    input logic          load_en,
    input logic          step_en,
    input logic          wr_mode
);
    assert_reset_zero_R9: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);
    assert_load_captures_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> cur_addr == $past(ext_addr));
    assert_wait_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !step_en) |=> $stable(cur_addr));
    assert_upper_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(cur_addr[AW-1:2]));
    assert_step_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (!adv_n && strb_p_n && strb_c_n));
    assert_write_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && wr_mode) |-> !wbeat_n);
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .strb_p_n(strb_p_n), .strb_c_n(strb_c_n),
    .adv_n(adv_n), .wbeat_n(wbeat_n), .ext_addr(ext_addr),
    .cur_addr(cur_addr), .load_en(load_en), .step_en(step_en),
    .wr_mode(wr_mode)
);

// File: tb/burst_seq_test.sv
// Bench for burst_seq: behavioural model compared every clock.
module burst_seq_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_ok = 1'b0;
    logic          strb_p_n = 1'b1;
    logic          strb_c_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          wbeat_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;

    int tests = 0;
    int fails = 0;
    int m_base = 0;
    int m_beat = 0;
    int m_wr = 0;

    burst_seq #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .strb_p_n(strb_p_n),
        .strb_c_n(strb_c_n), .adv_n(adv_n), .wbeat_n(wbeat_n),
        .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr)
    );

    always #4 clk = ~clk;

    function automatic int model_addr();
        int lo;
        if (order_sel) lo = (m_base % 4) ^ m_beat;
        else           lo = ((m_base % 4) + m_beat) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    // One clock: apply inputs, update model at the edge, compare after it.
    task automatic cyc(input logic rn, input logic so, input logic p,
                       input logic c, input logic a, input logic w,
                       input logic [AW-1:0] ad, input string tag);
        int ld;
        int st;
        rst_n = rn; start_ok = so; strb_p_n = p; strb_c_n = c;
        adv_n = a; wbeat_n = w; ext_addr = ad;
        @(posedge clk);
        ld = (so && (!p || !c)) ? 1 : 0;
        st = (!ld && p && c && !a && (!(m_wr != 0 || !w) || !w)) ? 1 : 0;
        if (!rn) begin
            m_base = 0; m_beat = 0; m_wr = 0;
        end else if (ld != 0) begin
            m_base = int'(ad); m_beat = 0; m_wr = (p && !w) ? 1 : 0;
        end else begin
            if (st != 0) m_beat = (m_beat + 1) % 4;
            if (!w) m_wr = 1;
        end
        #2;
        tests++;
        if (int'(cur_addr) != model_addr()) begin
            fails++;
            $display("FAIL %s: cur_addr=%h expected=%h", tag, cur_addr,
                     model_addr());
        end
    endtask

    initial begin
        @(negedge clk);
        cyc(0, 0, 1, 1, 1, 1, 16'h0000, "R9 reset");
        // XOR order from start ...6
        order_sel = 1'b1;
        cyc(1, 1, 0, 1, 1, 1, 16'h1236, "R3 load");
        cyc(1, 0, 1, 1, 0, 1, 16'hFFFF, "R1 beat1");
        cyc(1, 0, 1, 1, 1, 1, 16'hFFFF, "R6 wait");
        cyc(1, 0, 1, 1, 0, 1, 16'hFFFF, "R1 beat2");
        cyc(1, 0, 1, 1, 0, 1, 16'hFFFF, "R1 beat3");
        cyc(1, 0, 1, 1, 0, 1, 16'hFFFF, "R8 wrap");
        // Strobe low without start_ok must hold
        cyc(1, 0, 0, 1, 0, 1, 16'h0000, "R5 strobe hold");
        cyc(1, 0, 1, 0, 0, 1, 16'h0000, "R5 strobe hold");
        // Linear order from ...7 with upper bits fixed
        order_sel = 1'b0;
        cyc(1, 1, 1, 0, 1, 1, 16'hABC7, "R3 load c");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R2 beat1");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R2 beat2");
        // Load with advance low on the same edge
        cyc(1, 1, 0, 1, 0, 1, 16'h5551, "R4 load beats adv");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R2 beat1");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R2 beat2");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R2 beat3");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R8 wrap");
        // Write burst by controller strobe with byte write
        order_sel = 1'b1;
        cyc(1, 1, 1, 0, 1, 0, 16'h0F01, "R7 write load");
        cyc(1, 0, 1, 1, 0, 0, 16'h0000, "R7 step");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R7 no byte hold");
        cyc(1, 0, 1, 1, 0, 0, 16'h0000, "R7 step");
        // Processor load clears write mode; byte write on a step edge
        cyc(1, 1, 0, 1, 1, 0, 16'h2222, "R7 p load");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R7 read step");
        cyc(1, 0, 1, 1, 0, 0, 16'h0000, "R7 enter write");
        cyc(1, 0, 1, 1, 0, 1, 16'h0000, "R7 write hold");
        cyc(1, 0, 1, 1, 1, 0, 16'h0000, "R6 wait");
        // Reset mid burst
        cyc(0, 1, 0, 1, 0, 1, 16'h7777, "R9 reset mid");
        cyc(1, 0, 1, 1, 1, 1, 16'h0000, "R9 after");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule